// File: doc/BRIEF.md
# Node-ID Dimension Routing Switch

This block steers circuit-switched packets through one node of a multi-node network. Every node has a unique identifier. Each input carries a stream of tokens. The first token of a packet is a header, and that header carries the destination node identifier. The switch compares the destination with its own identifier. On a match, the packet goes to the local core port. On a mismatch, the switch finds the most significant bit where the two identifiers differ. That bit index addresses a routing table, and the table returns a direction. Each direction drives exactly one outgoing link.

The route chosen for the header becomes a circuit, and every later token of the same packet follows it whatever its value. A dedicated end-of-packet control token is forwarded and then frees the circuit. A header whose output is held by another packet is stalled by backpressure until that output is freed. When several inputs ask for the same free output in the same cycle, the lowest-numbered input wins. Software loads the routing table one entry per cycle through a write port.

Top module: `node_router`

## Requirements
- R1: After reset no circuit exists: every `out_valid` bit is 0, and `in_ready` is 0 for every input that has no header pending.
- R2: A header whose data equals `own_id` is forwarded unchanged on the local port, which is output index N_LINK (index 4 with default parameters).
- R3: A header whose data differs from `own_id` is routed to link `tbl[p]`, where p is the index of the most significant bit in which the two differ (bit 15 down to bit 0). Link number k is output index k.
- R4: A write with `tbl_we` high stores `tbl_dir` into entry `tbl_addr`. Any header routed in a later cycle uses the new entry.
- R5: Every token after the header follows the header's output, whatever its data value, until the packet ends.
- R6: A control token (`in_ctrl`=1) with data value 1 ends the packet. It is forwarded on the circuit, and the circuit is freed after it transfers. A control token with any other data value is forwarded without ending the packet.
- R7: A header whose output is held by another input's circuit sees `in_ready`=0 and produces no `out_valid`. It is routed in the cycle after that circuit's end token transfers.
- R8: When two inputs present headers for the same free output in the same cycle, the lower-numbered input gets the output and the other waits.
- R9: On a circuit, `out_valid` follows `in_valid` and `in_ready` follows `out_ready`. While `out_ready` is low the token is held unchanged on the output.
- R10: Circuits from different inputs to different outputs carry tokens in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| own_id | input | 16 | Identifier of this node |
| tbl_we | input | 1 | Routing table write strobe |
| tbl_addr | input | 4 | Routing table entry to write (a bit index) |
| tbl_dir | input | 2 | Direction to store |
| in_valid | input | N_IN | Token present, one bit per input |
| in_ctrl | input | N_IN | Token is a control token, one bit per input |
| in_data | input | N_IN*16 | Token data, input i in bits [16i+15:16i] |
| in_ready | output | N_IN | Token accepted, one bit per input |
| out_valid | output | N_LINK+1 | Token present, one bit per output; the top bit is the local port |
| out_ctrl | output | N_LINK+1 | Control flag of the forwarded token |
| out_data | output | (N_LINK+1)*16 | Forwarded token data, output o in bits [16o+15:16o] |
| out_ready | input | N_LINK+1 | Downstream accepts the token |

## Verification
The assertions assume that every source keeps a token's valid, control flag and data steady until the token is accepted. They also assume that the first token of each packet is a header and not an end token. Under these assumptions a stalled output must keep its token unchanged, and tokens accepted on the inputs must equal tokens delivered on the outputs in every cycle. The bench drives each token from the falling edge and holds it until it has seen the matching ready. It always opens a packet with a data header. Table writes use only in-range entries and directions.

// File: rtl/node_router_pkg.sv
package node_router_pkg;

    parameter int TOK_W = 16;
    localparam int BIT_IDX_W = $clog2(TOK_W);
    localparam logic [TOK_W-1:0] END_CODE = TOK_W'(1);

    typedef struct packed {
        logic             ctrl;
        logic [TOK_W-1:0] data;
    } tok_t;

    typedef enum logic {
        PS_IDLE = 1'b0,
        PS_BUSY = 1'b1
    } pstate_e;

    function automatic logic is_end(tok_t t);
        return t.ctrl && (t.data == END_CODE);
    endfunction

    // Index of the highest set bit of a non-zero difference vector.
    function automatic logic [BIT_IDX_W-1:0] top_set_bit(logic [TOK_W-1:0] x);
        logic [BIT_IDX_W-1:0] pos;
        pos = '0;
        for (int b = 0; b < TOK_W; b++) begin
            if (x[b]) pos = BIT_IDX_W'(b);
        end
        return pos;
    endfunction

endpackage

// File: rtl/route_table.sv
module route_table #(
    parameter int N_ENT = 16,
    parameter int DIR_W = 2,
    localparam int ADDR_W = $clog2(N_ENT)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   we,
    input  logic [ADDR_W-1:0]      addr,
    input  logic [DIR_W-1:0]       dir,
    output logic [N_ENT*DIR_W-1:0] tbl_flat
);
    logic [DIR_W-1:0] ent_q [N_ENT];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int e = 0; e < N_ENT; e++) ent_q[e] <= '0;
        end else if (we) begin
            ent_q[addr] <= dir;
        end
    end

    for (genvar e = 0; e < N_ENT; e++) begin : g_flat
        assign tbl_flat[e*DIR_W +: DIR_W] = ent_q[e];
    end
endmodule

// File: rtl/route_select.sv
module route_select
    import node_router_pkg::*;
#(
    parameter int N_LINK = 4,
    localparam int DIR_W = $clog2(N_LINK),
    localparam int N_OUT = N_LINK + 1,
    localparam int OUT_W = $clog2(N_OUT)
) (
    input  logic [TOK_W-1:0]       dest,
    input  logic [TOK_W-1:0]       own,
    input  logic [TOK_W*DIR_W-1:0] tbl_flat,
    output logic [OUT_W-1:0]       sel
);
    logic [TOK_W-1:0]     diff;
    logic [BIT_IDX_W-1:0] pos;
    logic [DIR_W-1:0]     dir;

    always_comb begin
        diff = dest ^ own;
        pos  = top_set_bit(diff);
        dir  = tbl_flat[pos*DIR_W +: DIR_W];
        if (diff == '0) sel = OUT_W'(N_LINK);
        else            sel = OUT_W'(dir);
    end
endmodule

// File: rtl/port_tracker.sv
module port_tracker
    import node_router_pkg::*;
#(
    parameter int OUT_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  tok_t             tok,
    input  logic             xfer,
    input  logic             grant,
    input  logic [OUT_W-1:0] want,
    output logic             busy,
    output logic [OUT_W-1:0] hold
);
    pstate_e          st_q;
    logic [OUT_W-1:0] hold_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= PS_IDLE;
            hold_q <= '0;
        end else begin
            unique case (st_q)
                PS_IDLE: if (grant && !(xfer && is_end(tok))) begin
                    st_q   <= PS_BUSY;
                    hold_q <= want;
                end
                PS_BUSY: if (xfer && is_end(tok)) st_q <= PS_IDLE;
                default: st_q <= PS_IDLE;
            endcase
        end
    end

    assign busy = (st_q == PS_BUSY);
    assign hold = hold_q;
endmodule

// File: rtl/node_router.sv
module node_router
    import node_router_pkg::*;
#(
    parameter int N_IN   = 2,
    parameter int N_LINK = 4,
    localparam int ID_W   = TOK_W,
    localparam int N_OUT  = N_LINK + 1,
    localparam int OUT_W  = $clog2(N_OUT),
    localparam int DIR_W  = $clog2(N_LINK),
    localparam int ADDR_W = $clog2(ID_W)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [ID_W-1:0]        own_id,
    input  logic                   tbl_we,
    input  logic [ADDR_W-1:0]      tbl_addr,
    input  logic [DIR_W-1:0]       tbl_dir,
    input  logic [N_IN-1:0]        in_valid,
    input  logic [N_IN-1:0]        in_ctrl,
    input  logic [N_IN*TOK_W-1:0]  in_data,
    output logic [N_IN-1:0]        in_ready,
    output logic [N_OUT-1:0]       out_valid,
    output logic [N_OUT-1:0]       out_ctrl,
    output logic [N_OUT*TOK_W-1:0] out_data,
    input  logic [N_OUT-1:0]       out_ready
);
    logic [ID_W*DIR_W-1:0] tbl_flat;
    tok_t                  in_tok  [N_IN];
    logic [OUT_W-1:0]      want    [N_IN];
    logic [OUT_W-1:0]      hold    [N_IN];
    logic [OUT_W-1:0]      sel     [N_IN];
    logic [N_IN-1:0]       busy;
    logic [N_IN-1:0]       grant;
    logic [N_IN-1:0]       conn;
    logic [N_OUT-1:0]      taken;

    route_table #(.N_ENT(ID_W), .DIR_W(DIR_W)) table_i (
        .clk      (clk),
        .rst      (rst),
        .we       (tbl_we),
        .addr     (tbl_addr),
        .dir      (tbl_dir),
        .tbl_flat (tbl_flat)
    );

    for (genvar i = 0; i < N_IN; i++) begin : g_in
        assign in_tok[i].ctrl = in_ctrl[i];
        assign in_tok[i].data = in_data[i*TOK_W +: TOK_W];

        route_select #(.N_LINK(N_LINK)) sel_i (
            .dest     (in_tok[i].data),
            .own      (own_id),
            .tbl_flat (tbl_flat),
            .sel      (want[i])
        );

        port_tracker #(.OUT_W(OUT_W)) trk_i (
            .clk   (clk),
            .rst   (rst),
            .tok   (in_tok[i]),
            .xfer  (in_valid[i] && in_ready[i]),
            .grant (grant[i]),
            .want  (want[i]),
            .busy  (busy[i]),
            .hold  (hold[i])
        );
    end

    // Fixed-priority circuit setup: outputs held by a circuit are taken,
    // then idle inputs claim free outputs from index 0 upward.
    always_comb begin
        taken = '0;
        grant = '0;
        for (int i = 0; i < N_IN; i++) begin
            if (busy[i]) taken[hold[i]] = 1'b1;
        end
        for (int i = 0; i < N_IN; i++) begin
            if (!busy[i] && in_valid[i] && !taken[want[i]]) begin
                grant[i]       = 1'b1;
                taken[want[i]] = 1'b1;
            end
        end
        for (int i = 0; i < N_IN; i++) begin
            conn[i] = busy[i] || grant[i];
            sel[i]  = busy[i] ? hold[i] : want[i];
        end
    end

    always_comb begin
        out_valid = '0;
        out_ctrl  = '0;
        out_data  = '0;
        in_ready  = '0;
        for (int o = 0; o < N_OUT; o++) begin
            for (int i = 0; i < N_IN; i++) begin
                if (conn[i] && sel[i] == OUT_W'(o)) begin
                    out_valid[o]                 = in_valid[i];
                    out_ctrl[o]                  = in_tok[i].ctrl;
                    out_data[o*TOK_W +: TOK_W]   = in_tok[i].data;
                    in_ready[i]                  = out_ready[o];
                end
            end
        end
    end
endmodule

// File: rtl/node_router_chk.sv
module node_router_chk
    import node_router_pkg::*;
#(
    parameter int N_IN   = 2,
    parameter int N_LINK = 4,
    localparam int N_OUT  = N_LINK + 1,
    localparam int DIR_W  = $clog2(N_LINK),
    localparam int ADDR_W = $clog2(TOK_W)
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   tbl_we,
    input logic [ADDR_W-1:0]      tbl_addr,
    input logic [DIR_W-1:0]       tbl_dir,
    input logic [TOK_W*DIR_W-1:0] tbl_flat,
    input logic [N_IN-1:0]        in_valid,
    input logic [N_IN-1:0]        in_ready,
    input logic [N_OUT-1:0]       out_valid,
    input logic [N_OUT-1:0]       out_ctrl,
    input logic [N_OUT*TOK_W-1:0] out_data,
    input logic [N_OUT-1:0]       out_ready
);
    // R9: every accepted input token appears on exactly one output
    a_r9_transfer_balance: assert property (@(posedge clk) disable iff (rst)
        $countones(in_valid & in_ready) == $countones(out_valid & out_ready));

    // R10: outputs are never handed more tokens than there are inputs
    a_r10_out_bound: assert property (@(posedge clk) disable iff (rst)
        $countones(out_valid) <= N_IN);

    // R4: a table write is visible in the following cycle
    a_r4_table_write: assert property (@(posedge clk) disable iff (rst)
        tbl_we |=> tbl_flat[$past(tbl_addr)*DIR_W +: DIR_W] == $past(tbl_dir));

    for (genvar o = 0; o < N_OUT; o++) begin : g_out
        // R9: a stalled output keeps its token
        a_r9_stall_stable: assert property (@(posedge clk) disable iff (rst)
            (out_valid[o] && !out_ready[o]) |=>
                (out_valid[o] && $stable(out_ctrl[o]) &&
                 $stable(out_data[o*TOK_W +: TOK_W])));
    end
endmodule

bind node_router node_router_chk #(.N_IN(N_IN), .N_LINK(N_LINK)) chk_i (.*);

// File: tb/node_router_tb_top.sv
module node_router_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int N_IN   = 2;
    localparam int N_LINK = 4;
    localparam int N_OUT  = N_LINK + 1;
    localparam int TW     = 16;
    localparam int LOCAL  = N_LINK;
    localparam logic [15:0] OWN = 16'hA5C3;

    logic clk = 1'b0;
    logic rst;
    logic [15:0]         own_id;
    logic                tbl_we;
    logic [3:0]          tbl_addr;
    logic [1:0]          tbl_dir;
    logic [N_IN-1:0]     in_valid, in_ctrl, in_ready;
    logic [N_IN*TW-1:0]  in_data;
    logic [N_OUT-1:0]    out_valid, out_ctrl, out_ready;
    logic [N_OUT*TW-1:0] out_data;

    int n_chk = 0;
    int n_err = 0;
    logic [1:0] tbl_model [16];

    always #(CLK_PERIOD/2) clk = ~clk;

    node_router #(.N_IN(N_IN), .N_LINK(N_LINK)) dut_i (
        .clk(clk), .rst(rst), .own_id(own_id),
        .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_dir(tbl_dir),
        .in_valid(in_valid), .in_ctrl(in_ctrl), .in_data(in_data), .in_ready(in_ready),
        .out_valid(out_valid), .out_ctrl(out_ctrl), .out_data(out_data), .out_ready(out_ready)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic drive(int i, logic v, logic c, logic [15:0] d);
        in_valid[i] = v;
        in_ctrl[i]  = c;
        in_data[i*TW +: TW] = d;
    endtask

    function automatic logic [15:0] odata(int o);
        return out_data[o*TW +: TW];
    endfunction

    // Expected output from the requirement text (R2, R3)
    function automatic int exp_out(logic [15:0] dest);
        if (dest == OWN) return LOCAL;
        for (int b = 15; b >= 0; b--) begin
            if (dest[b] != OWN[b]) return int'(tbl_model[b]);
        end
        return LOCAL;
    endfunction

    task automatic wr_tbl(int a, logic [1:0] d);
        tbl_we = 1'b1; tbl_addr = 4'(a); tbl_dir = d;
        tbl_model[a] = d;
        step();
        tbl_we = 1'b0;
    endtask

    // At #1 after a drive: token i must appear alone on output o
    task automatic expect_route(string tag, int i, int o, logic c, logic [15:0] d);
        #1;
        chk({tag, " out_valid"}, 32'(out_valid), 32'(1 << o));
        chk({tag, " out_data"}, 32'(odata(o)), 32'(d));
        chk({tag, " out_ctrl"}, 32'(out_ctrl[o]), 32'(c));
        chk({tag, " in_ready"}, 32'(in_ready[i]), 32'd1);
    endtask

    task automatic t_reset();
        #1;
        chk("R1 out_valid after reset", 32'(out_valid), 32'd0);
        chk("R1 in_ready after reset", 32'(in_ready), 32'd0);
    endtask

    task automatic t_local();
        drive(0, 1, 0, OWN);
        expect_route("R2 local header", 0, LOCAL, 0, OWN);
        step();
        drive(0, 1, 0, 16'h0000);
        expect_route("R5 body follows circuit", 0, LOCAL, 0, 16'h0000);
        step();
        drive(0, 1, 1, 16'h0002);
        expect_route("R6 non-end control forwarded", 0, LOCAL, 1, 16'h0002);
        step();
        drive(0, 1, 0, 16'hFFFF);
        expect_route("R6 circuit kept after non-end control", 0, LOCAL, 0, 16'hFFFF);
        step();
        drive(0, 1, 1, 16'h0001);
        expect_route("R6 end token forwarded", 0, LOCAL, 1, 16'h0001);
        step();
        drive(0, 0, 0, 16'h0);
        #1 chk("R6 nothing after end", 32'(out_valid), 32'd0);
    endtask

    task automatic t_mismatch();
        logic [15:0] deltas [5] = '{16'h8000, 16'h0101, 16'h0006, 16'h0001, 16'h0FF0};
        foreach (deltas[k]) begin
            logic [15:0] d;
            d = OWN ^ deltas[k];
            @(negedge clk);
            drive(0, 1, 0, d);
            expect_route("R3 mismatch header", 0, exp_out(d), 0, d);
            step();
            drive(0, 1, 1, 16'h0001);
            expect_route("R6 end released", 0, exp_out(d), 1, 16'h0001);
            step();
            drive(0, 0, 0, 16'h0);
        end
    endtask

    task automatic t_rewrite();
        wr_tbl(15, 2'd1);
        drive(0, 1, 0, OWN ^ 16'h8000);
        expect_route("R4 rewritten entry used", 0, 1, 0, OWN ^ 16'h8000);
        step();
        drive(0, 1, 1, 16'h0001);
        step();
        drive(0, 0, 0, 16'h0);
    endtask

    task automatic t_backpressure();
        drive(0, 1, 0, OWN ^ 16'h0800);
        expect_route("R7 holder header", 0, 3, 0, OWN ^ 16'h0800);
        step();
        drive(0, 0, 0, 16'h0);
        drive(1, 1, 0, OWN ^ 16'h0900);
        #1;
        chk("R7 blocked in_ready", 32'(in_ready[1]), 32'd0);
        chk("R7 blocked out_valid", 32'(out_valid), 32'd0);
        step();
        #1 chk("R7 still blocked", 32'(in_ready[1]), 32'd0);
        @(negedge clk);
        drive(0, 1, 1, 16'h0001);
        #1;
        chk("R7 holder end data", 32'(odata(3)), 32'h0001);
        chk("R7 blocked during end", 32'(in_ready[1]), 32'd0);
        step();
        drive(0, 0, 0, 16'h0);
        expect_route("R7 waiting header routed", 1, 3, 0, OWN ^ 16'h0900);
        step();
        drive(1, 1, 1, 16'h0001);
        step();
        drive(1, 0, 0, 16'h0);
    endtask

    task automatic t_priority();
        drive(0, 1, 0, OWN ^ 16'h0020);
        drive(1, 1, 0, OWN ^ 16'h0030);
        #1;
        chk("R8 winner data", 32'(odata(1)), 32'(OWN ^ 16'h0020));
        chk("R8 ready pattern", 32'(in_ready), 32'b01);
        step();
        drive(0, 1, 1, 16'h0001);
        #1 chk("R8 loser waits", 32'(in_ready[1]), 32'd0);
        step();
        drive(0, 0, 0, 16'h0);
        expect_route("R8 loser routed later", 1, 1, 0, OWN ^ 16'h0030);
        step();
        drive(1, 1, 1, 16'h0001);
        step();
        drive(1, 0, 0, 16'h0);
    endtask

    task automatic t_parallel();
        drive(0, 1, 0, OWN);
        drive(1, 1, 0, OWN ^ 16'h0004);
        #1;
        chk("R10 both outputs valid", 32'(out_valid), 32'b10100);
        chk("R10 both ready", 32'(in_ready), 32'b11);
        chk("R10 link data", 32'(odata(2)), 32'(OWN ^ 16'h0004));
        step();
        drive(0, 1, 1, 16'h0001);
        drive(1, 1, 1, 16'h0001);
        #1 chk("R10 both ends", 32'(out_valid & out_ctrl), 32'b10100);
        step();
        drive(0, 0, 0, 16'h0);
        drive(1, 0, 0, 16'h0);
    endtask

    task automatic t_stall();
        out_ready = '0;
        drive(0, 1, 0, OWN ^ 16'h0100);
        #1;
        chk("R9 stalled valid", 32'(out_valid), 32'd1);
        chk("R9 stalled ready", 32'(in_ready[0]), 32'd0);
        step();
        #1;
        chk("R9 stall held data", 32'(odata(0)), 32'(OWN ^ 16'h0100));
        chk("R9 stall held valid", 32'(out_valid), 32'd1);
        @(negedge clk);
        out_ready = '1;
        #1 chk("R9 ready follows", 32'(in_ready[0]), 32'd1);
        step();
        drive(0, 1, 1, 16'h0001);
        step();
        drive(0, 0, 0, 16'h0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_err++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        rst = 1'b1; own_id = OWN; tbl_we = 1'b0; tbl_addr = '0; tbl_dir = '0;
        in_valid = '0; in_ctrl = '0; in_data = '0; out_ready = '1;
        for (int e = 0; e < 16; e++) tbl_model[e] = 2'd0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        @(negedge clk);
        for (int e = 0; e < 16; e++) wr_tbl(e, 2'(e % 4));
        t_local();
        t_mismatch();
        @(negedge clk);
        t_rewrite();
        t_backpressure();
        t_priority();
        t_parallel();
        t_stall();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule